// File: doc/BRIEF.md
# Privileged Trap Entry Sequencer

This block turns a trap request into the state updates a hart makes on trap entry. A request carries a cause word, whose most significant bit marks an interrupt, together with the faulting PC and an optional bad address. The block also reads the current privilege, the interrupt-enable bits, both handler vector registers, both delegation masks and the debug controls. From these it picks one of four outcomes:

- enter debug mode on an enabled breakpoint;
- stay in debug mode and jump to the debug exception address;
- enter the supervisor handler;
- enter the machine handler.

A request is a single-cycle pulse. On the next clock edge the block presents the new PC, the new privilege and the write strobes for the cause, epc, bad-address, status and debug-PC registers, all in the same cycle. It also presents the clear for the load reservation. The surrounding core applies these writes. A status strobe means: write the saved-enable bit and the saved-privilege field from the outputs, and clear the live enable bit.

Top module: `trap_entry_seq`

## Requirements
- R1: A one-cycle pulse on `i_req` produces exactly one cycle of `o_valid` on the next clock edge. All write strobes are valid only in that cycle. In a cycle after no request, `o_valid`, `o_prv_we` and all write strobes are low.
- R2: Debug entry happens when the cause equals the breakpoint code (3, interrupt bit clear) and `i_ebreak_en[i_prv]` is set. The bits of `i_ebreak_en` are indexed by privilege: U=0, S=1, H=2, M=3. Debug entry raises `o_dbg_enter` and `o_dpc_we` (the saved PC is `o_epc`). It reports `o_dbg_cause` = 1 and `o_dbg_prv` = prior privilege, sets privilege M (3) and sets the PC to `DBG_ROM_START`. It writes no cause, epc, bad address or status and does not clear the reservation. This check takes priority over R3.
- R3: Otherwise, when `i_dbg_cause` is nonzero, the PC becomes `DBG_ROM_EXC`, `o_prv_we` stays low, `o_prv` repeats `i_prv`, and every other strobe stays low.
- R4: The delegation index is the cause with its top bit cleared. Interrupts use `i_mideleg` and exceptions use `i_medeleg`. The supervisor handler is chosen only when all three hold: the privilege is U or S, the index is below XLEN, and the selected mask bit at that index is 1. In every other case the machine handler is chosen.
- R5: Supervisor entry sets the PC to `i_stvec` with bits 1:0 cleared. It raises `o_scause_we` and `o_sepc_we`, and raises `o_sbad_we` only when `i_bad_vld` is set.
- R6: Supervisor entry raises `o_sstat_we` with `o_spie` = `i_sie` and `o_spp` = `i_prv[0]`, and sets privilege S (1).
- R7: Machine entry sets the PC to `i_mtvec` with bits 1:0 cleared. When `i_mtvec[0]` is 1 and the trap is an interrupt, it adds 4 × index. Exceptions never get the offset.
- R8: Machine entry raises `o_mcause_we` and `o_mepc_we`, and raises `o_mbad_we` only when `i_bad_vld` is set. It raises `o_mstat_we` with `o_mpie` = `i_mie` and `o_mpp` = `i_prv`, and sets privilege M.
- R9: `o_resv_clr` is raised on supervisor and machine entry only.
- R10: A trap taken from H (2) is never delegated and records MPP = 2. The written privilege is never the H encoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| i_req | input | 1 | Trap request pulse |
| i_cause | input | XLEN | Cause word, top bit = interrupt |
| i_epc | input | XLEN | Faulting PC |
| i_bad_vld | input | 1 | Bad address present |
| i_badaddr | input | XLEN | Bad address |
| i_prv | input | 2 | Current privilege |
| i_mie | input | 1 | Machine interrupt enable |
| i_sie | input | 1 | Supervisor interrupt enable |
| i_mtvec | input | XLEN | Machine vector register |
| i_stvec | input | XLEN | Supervisor vector register |
| i_medeleg | input | XLEN | Exception delegation mask |
| i_mideleg | input | XLEN | Interrupt delegation mask |
| i_dbg_cause | input | 3 | Current debug cause, nonzero while in debug mode |
| i_ebreak_en | input | 4 | Breakpoint-to-debug enables per privilege |
| o_valid | output | 1 | Trap committed this cycle |
| o_pc | output | XLEN | Next PC |
| o_prv_we | output | 1 | Privilege write strobe |
| o_prv | output | 2 | Next privilege |
| o_mcause_we | output | 1 | Machine cause write |
| o_scause_we | output | 1 | Supervisor cause write |
| o_cause | output | XLEN | Cause value |
| o_mepc_we | output | 1 | Machine epc write |
| o_sepc_we | output | 1 | Supervisor epc write |
| o_epc | output | XLEN | Saved PC value (epc or debug PC) |
| o_mbad_we | output | 1 | Machine bad-address write |
| o_sbad_we | output | 1 | Supervisor bad-address write |
| o_badaddr | output | XLEN | Bad-address value |
| o_mstat_we | output | 1 | Machine status update |
| o_mpie | output | 1 | New machine saved enable |
| o_mpp | output | 2 | New machine saved privilege |
| o_sstat_we | output | 1 | Supervisor status update |
| o_spie | output | 1 | New supervisor saved enable |
| o_spp | output | 1 | New supervisor saved privilege |
| o_resv_clr | output | 1 | Clear load reservation |
| o_dbg_enter | output | 1 | Debug mode entry |
| o_dbg_cause | output | 3 | Debug cause value (software breakpoint) |
| o_dbg_prv | output | 2 | Privilege saved on debug entry |
| o_dpc_we | output | 1 | Debug PC write |

## Verification
The block has one register stage, so any wrong routing or target shows up on the ports in the cycle right after the request. A wrong delegation index or mask choice appears as the wrong cause strobe and a supervisor PC where a machine PC was due. A wrong vector offset shows as a PC off by a multiple of four. A wrong priority between breakpoint entry and debug-mode trapping shows as a debug-exception address with no debug-PC write. The sweeps cover every privilege, both trap kinds, causes inside and outside the mask width, and every breakpoint-enable pattern. Each transaction is compared field by field against an arithmetic model.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
   localparam logic [1:0] PRV_U = 2'd0;
   localparam logic [1:0] PRV_S = 2'd1;
   localparam logic [1:0] PRV_H = 2'd2;
   localparam logic [1:0] PRV_M = 2'd3;

   typedef enum logic [1:0] {
      RT_MACH      = 2'd0,
      RT_SUPER     = 2'd1,
      RT_DBG_ENTER = 2'd2,
      RT_DBG_EXC   = 2'd3
   } route_e;

   function automatic logic [1:0] settle_prv(input logic [1:0] p);
      return (p == PRV_H) ? PRV_U : p;
   endfunction
endpackage

// File: rtl/trap_route.sv
module trap_route
   import trap_seq_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int BRK_CAUSE = 3
) (
   input  logic [XLEN-1:0] i_cause,
   input  logic [1:0]      i_prv,
   input  logic [XLEN-1:0] i_medeleg,
   input  logic [XLEN-1:0] i_mideleg,
   input  logic [2:0]      i_dbg_cause,
   input  logic [3:0]      i_ebreak_en,
   output route_e          o_route,
   output logic            o_is_irq,
   output logic [XLEN-1:0] o_index
);
   localparam int IW = $clog2(XLEN);

   logic            in_range;
   logic [XLEN-1:0] mask;
   logic            deleg_bit;
   logic            brk_hit;

   assign o_is_irq  = i_cause[XLEN-1];
   assign o_index   = {1'b0, i_cause[XLEN-2:0]};
   assign in_range  = (o_index[XLEN-1:IW] == '0);
   assign mask      = o_is_irq ? i_mideleg : i_medeleg;
   assign deleg_bit = mask[o_index[IW-1:0]];
   assign brk_hit   = (i_cause == XLEN'(BRK_CAUSE)) && i_ebreak_en[i_prv];

   always_comb begin
      if (brk_hit)
         o_route = RT_DBG_ENTER;
      else if (i_dbg_cause != 3'd0)
         o_route = RT_DBG_EXC;
      else if ((i_prv <= PRV_S) && in_range && deleg_bit)
         o_route = RT_SUPER;
      else
         o_route = RT_MACH;
   end
endmodule

// File: rtl/trap_target.sv
module trap_target
   import trap_seq_pkg::*;
#(
   parameter int                  XLEN          = 32,
   parameter bit                  VEC_EN        = 1'b1,
   parameter logic [XLEN-1:0]     DBG_ROM_START = 'h800,
   parameter logic [XLEN-1:0]     DBG_ROM_EXC   = 'h808
) (
   input  route_e          i_route,
   input  logic            i_is_irq,
   input  logic [XLEN-1:0] i_index,
   input  logic [1:0]      i_prv,
   input  logic [XLEN-1:0] i_mtvec,
   input  logic [XLEN-1:0] i_stvec,
   output logic [XLEN-1:0] o_pc,
   output logic [1:0]      o_prv
);
   logic [XLEN-1:0] m_base;
   logic [XLEN-1:0] s_base;
   logic [XLEN-1:0] m_off;

   assign m_base = {i_mtvec[XLEN-1:2], 2'b00};
   assign s_base = {i_stvec[XLEN-1:2], 2'b00};

   generate
      if (VEC_EN) begin : g_vec
         assign m_off = (i_mtvec[0] && i_is_irq) ? {i_index[XLEN-3:0], 2'b00} : '0;
      end else begin : g_direct
         assign m_off = '0;
      end
   endgenerate

   always_comb begin
      unique case (i_route)
         RT_DBG_ENTER: begin o_pc = DBG_ROM_START;  o_prv = settle_prv(PRV_M); end
         RT_DBG_EXC:   begin o_pc = DBG_ROM_EXC;    o_prv = i_prv;              end
         RT_SUPER:     begin o_pc = s_base;         o_prv = settle_prv(PRV_S); end
         default:      begin o_pc = m_base + m_off; o_prv = settle_prv(PRV_M); end
      endcase
   end
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
   import trap_seq_pkg::*;
#(
   parameter int              XLEN          = 32,
   parameter bit              VEC_EN        = 1'b1,
   parameter int              BRK_CAUSE     = 3,
   parameter logic [2:0]      DBG_SWBP      = 3'd1,
   parameter logic [XLEN-1:0] DBG_ROM_START = 'h800,
   parameter logic [XLEN-1:0] DBG_ROM_EXC   = 'h808
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            i_req,
   input  logic [XLEN-1:0] i_cause,
   input  logic [XLEN-1:0] i_epc,
   input  logic            i_bad_vld,
   input  logic [XLEN-1:0] i_badaddr,
   input  logic [1:0]      i_prv,
   input  logic            i_mie,
   input  logic            i_sie,
   input  logic [XLEN-1:0] i_mtvec,
   input  logic [XLEN-1:0] i_stvec,
   input  logic [XLEN-1:0] i_medeleg,
   input  logic [XLEN-1:0] i_mideleg,
   input  logic [2:0]      i_dbg_cause,
   input  logic [3:0]      i_ebreak_en,
   output logic            o_valid,
   output logic [XLEN-1:0] o_pc,
   output logic            o_prv_we,
   output logic [1:0]      o_prv,
   output logic            o_mcause_we,
   output logic            o_scause_we,
   output logic [XLEN-1:0] o_cause,
   output logic            o_mepc_we,
   output logic            o_sepc_we,
   output logic [XLEN-1:0] o_epc,
   output logic            o_mbad_we,
   output logic            o_sbad_we,
   output logic [XLEN-1:0] o_badaddr,
   output logic            o_mstat_we,
   output logic            o_mpie,
   output logic [1:0]      o_mpp,
   output logic            o_sstat_we,
   output logic            o_spie,
   output logic            o_spp,
   output logic            o_resv_clr,
   output logic            o_dbg_enter,
   output logic [2:0]      o_dbg_cause,
   output logic [1:0]      o_dbg_prv,
   output logic            o_dpc_we
);
   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("trap_entry_seq: XLEN must be 32 or 64");
      end
      if (BRK_CAUSE < 0 || BRK_CAUSE >= XLEN) begin : g_bad_brk
         $error("trap_entry_seq: BRK_CAUSE out of range");
      end
      if (DBG_ROM_START[1:0] != 2'b00 || DBG_ROM_EXC[1:0] != 2'b00) begin : g_bad_rom
         $error("trap_entry_seq: debug addresses must be word aligned");
      end
   endgenerate

   route_e          route;
   logic            is_irq;
   logic [XLEN-1:0] index;
   logic [XLEN-1:0] pc_nxt;
   logic [1:0]      prv_nxt;
   logic            to_m, to_s, to_dbg;

   trap_route #(.XLEN(XLEN), .BRK_CAUSE(BRK_CAUSE)) u_route (
      .i_cause     (i_cause),
      .i_prv       (i_prv),
      .i_medeleg   (i_medeleg),
      .i_mideleg   (i_mideleg),
      .i_dbg_cause (i_dbg_cause),
      .i_ebreak_en (i_ebreak_en),
      .o_route     (route),
      .o_is_irq    (is_irq),
      .o_index     (index)
   );

   trap_target #(.XLEN(XLEN), .VEC_EN(VEC_EN),
                 .DBG_ROM_START(DBG_ROM_START), .DBG_ROM_EXC(DBG_ROM_EXC)) u_target (
      .i_route  (route),
      .i_is_irq (is_irq),
      .i_index  (index),
      .i_prv    (i_prv),
      .i_mtvec  (i_mtvec),
      .i_stvec  (i_stvec),
      .o_pc     (pc_nxt),
      .o_prv    (prv_nxt)
   );

   assign to_m   = i_req && (route == RT_MACH);
   assign to_s   = i_req && (route == RT_SUPER);
   assign to_dbg = i_req && (route == RT_DBG_ENTER);

   assign o_dbg_cause = DBG_SWBP;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         o_valid     <= 1'b0;
         o_prv_we    <= 1'b0;
         o_mcause_we <= 1'b0;
         o_scause_we <= 1'b0;
         o_mepc_we   <= 1'b0;
         o_sepc_we   <= 1'b0;
         o_mbad_we   <= 1'b0;
         o_sbad_we   <= 1'b0;
         o_mstat_we  <= 1'b0;
         o_sstat_we  <= 1'b0;
         o_resv_clr  <= 1'b0;
         o_dbg_enter <= 1'b0;
         o_dpc_we    <= 1'b0;
         o_pc        <= '0;
         o_prv       <= '0;
         o_cause     <= '0;
         o_epc       <= '0;
         o_badaddr   <= '0;
         o_mpie      <= 1'b0;
         o_mpp       <= '0;
         o_spie      <= 1'b0;
         o_spp       <= 1'b0;
         o_dbg_prv   <= '0;
      end else begin
         o_valid     <= i_req;
         o_prv_we    <= to_m || to_s || to_dbg;
         o_mcause_we <= to_m;
         o_scause_we <= to_s;
         o_mepc_we   <= to_m;
         o_sepc_we   <= to_s;
         o_mbad_we   <= to_m && i_bad_vld;
         o_sbad_we   <= to_s && i_bad_vld;
         o_mstat_we  <= to_m;
         o_sstat_we  <= to_s;
         o_resv_clr  <= to_m || to_s;
         o_dbg_enter <= to_dbg;
         o_dpc_we    <= to_dbg;
         if (i_req) begin
            o_pc      <= pc_nxt;
            o_prv     <= prv_nxt;
            o_cause   <= i_cause;
            o_epc     <= i_epc;
            o_badaddr <= i_badaddr;
            o_mpie    <= i_mie;
            o_mpp     <= i_prv;
            o_spie    <= i_sie;
            o_spp     <= i_prv[0];
            o_dbg_prv <= i_prv;
         end
      end
   end
endmodule

// File: rtl/trap_entry_seq_chk.sv
module trap_entry_seq_chk #(
   parameter int              XLEN          = 32,
   parameter logic [XLEN-1:0] DBG_ROM_START = 'h800
) (
   input logic            clk,
   input logic            rst_n,
   input logic            i_req,
   input logic            i_bad_vld,
   input logic [1:0]      i_prv,
   input logic            o_valid,
   input logic [XLEN-1:0] o_pc,
   input logic            o_prv_we,
   input logic [1:0]      o_prv,
   input logic            o_mcause_we,
   input logic            o_scause_we,
   input logic            o_mepc_we,
   input logic            o_sepc_we,
   input logic            o_mbad_we,
   input logic            o_sbad_we,
   input logic            o_mstat_we,
   input logic            o_sstat_we,
   input logic            o_resv_clr,
   input logic            o_dbg_enter,
   input logic            o_dpc_we
);
   AST_REQ_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      i_req |=> o_valid);  // R1
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !i_req |=> !(o_valid || o_prv_we || o_mcause_we || o_scause_we || o_dbg_enter || o_resv_clr));  // R1
   AST_ONE_HANDLER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({o_mcause_we, o_scause_we, o_dbg_enter}));  // R4
   AST_DBG_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      o_dbg_enter |-> (o_prv_we && o_prv == 2'd3 && o_pc == DBG_ROM_START && o_dpc_we && !o_resv_clr));  // R2
   AST_DBGEXC_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && !o_prv_we) |-> !(o_mcause_we || o_scause_we || o_resv_clr || o_dpc_we || o_mstat_we || o_sstat_we));  // R3
   AST_SUPER_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      o_scause_we |-> ($past(i_prv) <= 2'd1));  // R4
   AST_SUPER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      o_scause_we |-> (o_prv == 2'd1 && o_pc[1:0] == 2'b00 && o_sepc_we && o_sstat_we));  // R6
   AST_MACH_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      o_mcause_we |-> (o_prv == 2'd3 && o_mepc_we && o_mstat_we));  // R8
   AST_RESV_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      o_resv_clr |-> (o_mcause_we || o_scause_we));  // R9
   AST_BAD_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (o_mbad_we || o_sbad_we) |-> $past(i_bad_vld));  // R5
   AST_NO_HYP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      o_prv_we |-> (o_prv != 2'd2));  // R10
endmodule

bind trap_entry_seq trap_entry_seq_chk #(.XLEN(XLEN), .DBG_ROM_START(DBG_ROM_START)) u_chk (
   .clk(clk), .rst_n(rst_n), .i_req(i_req), .i_bad_vld(i_bad_vld), .i_prv(i_prv),
   .o_valid(o_valid), .o_pc(o_pc), .o_prv_we(o_prv_we), .o_prv(o_prv),
   .o_mcause_we(o_mcause_we), .o_scause_we(o_scause_we), .o_mepc_we(o_mepc_we),
   .o_sepc_we(o_sepc_we), .o_mbad_we(o_mbad_we), .o_sbad_we(o_sbad_we),
   .o_mstat_we(o_mstat_we), .o_sstat_we(o_sstat_we), .o_resv_clr(o_resv_clr),
   .o_dbg_enter(o_dbg_enter), .o_dpc_we(o_dpc_we)
);

// File: tb/trap_entry_seq_bench.sv
module trap_entry_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int XLEN = 32;
   localparam logic [31:0] ROM_START = 32'h800;
   localparam logic [31:0] ROM_EXC   = 32'h808;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic i_req = 1'b0;
   logic [31:0] i_cause = '0, i_epc = '0, i_badaddr = '0;
   logic i_bad_vld = 1'b0;
   logic [1:0] i_prv = '0;
   logic i_mie = 1'b0, i_sie = 1'b0;
   logic [31:0] i_mtvec = '0, i_stvec = '0, i_medeleg = '0, i_mideleg = '0;
   logic [2:0] i_dbg_cause = '0;
   logic [3:0] i_ebreak_en = '0;

   logic o_valid, o_prv_we, o_mcause_we, o_scause_we, o_mepc_we, o_sepc_we;
   logic o_mbad_we, o_sbad_we, o_mstat_we, o_mpie, o_sstat_we, o_spie, o_spp;
   logic o_resv_clr, o_dbg_enter, o_dpc_we;
   logic [31:0] o_pc, o_cause, o_epc, o_badaddr;
   logic [1:0] o_prv, o_mpp, o_dbg_prv;
   logic [2:0] o_dbg_cause;

   int n_tests = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   trap_entry_seq u_trap_entry_seq (
      .clk(clk), .rst_n(rst_n), .i_req(i_req), .i_cause(i_cause), .i_epc(i_epc),
      .i_bad_vld(i_bad_vld), .i_badaddr(i_badaddr), .i_prv(i_prv), .i_mie(i_mie),
      .i_sie(i_sie), .i_mtvec(i_mtvec), .i_stvec(i_stvec), .i_medeleg(i_medeleg),
      .i_mideleg(i_mideleg), .i_dbg_cause(i_dbg_cause), .i_ebreak_en(i_ebreak_en),
      .o_valid(o_valid), .o_pc(o_pc), .o_prv_we(o_prv_we), .o_prv(o_prv),
      .o_mcause_we(o_mcause_we), .o_scause_we(o_scause_we), .o_cause(o_cause),
      .o_mepc_we(o_mepc_we), .o_sepc_we(o_sepc_we), .o_epc(o_epc),
      .o_mbad_we(o_mbad_we), .o_sbad_we(o_sbad_we), .o_badaddr(o_badaddr),
      .o_mstat_we(o_mstat_we), .o_mpie(o_mpie), .o_mpp(o_mpp),
      .o_sstat_we(o_sstat_we), .o_spie(o_spie), .o_spp(o_spp),
      .o_resv_clr(o_resv_clr), .o_dbg_enter(o_dbg_enter), .o_dbg_cause(o_dbg_cause),
      .o_dbg_prv(o_dbg_prv), .o_dpc_we(o_dpc_we)
   );

   function automatic logic [15:0] strobes_now();
      return {o_valid, o_prv_we, o_mcause_we, o_scause_we, o_mepc_we, o_sepc_we,
              o_mbad_we, o_sbad_we, o_mstat_we, o_sstat_we, o_resv_clr,
              o_dbg_enter, o_dpc_we, 3'b000};
   endfunction

   task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One transaction: drive at negedge, outputs registered at next posedge,
   // sampled at the following negedge; then one idle cycle must be quiet.
   task automatic run_trap(input string req);
      logic [31:0] idx, pc_e;
      logic irq, in_rng, dbit, brk, sup, mac, dent, dexc;
      logic [1:0] prv_e;
      logic [255:0] exp_v, act_v;
      irq    = i_cause[31];
      idx    = {1'b0, i_cause[30:0]};
      in_rng = idx < 32;
      dbit   = in_rng ? (irq ? i_mideleg[idx[4:0]] : i_medeleg[idx[4:0]]) : 1'b0;
      brk    = (i_cause == 32'd3) && i_ebreak_en[i_prv];
      dent   = brk;
      dexc   = !brk && (i_dbg_cause != 0);
      sup    = !dent && !dexc && (i_prv <= 2'd1) && dbit;
      mac    = !dent && !dexc && !sup;
      if (dent)      begin pc_e = ROM_START; prv_e = 2'd3; end
      else if (dexc) begin pc_e = ROM_EXC; prv_e = i_prv; end
      else if (sup)  begin pc_e = i_stvec & ~32'd3; prv_e = 2'd1; end
      else begin
         pc_e  = (i_mtvec & ~32'd3) + ((i_mtvec[0] && irq) ? idx * 4 : 32'd0);
         prv_e = 2'd3;
      end
      exp_v = {1'b1, pc_e, (dent|sup|mac), prv_e, mac, sup, i_cause, mac, sup, i_epc,
               mac & i_bad_vld, sup & i_bad_vld, i_badaddr, mac, i_mie, i_prv,
               sup, i_sie, i_prv[0], (mac|sup), dent, 3'd1, i_prv, dent};
      @(negedge clk);
      i_req = 1'b1;
      @(negedge clk);
      i_req = 1'b0;
      act_v = {o_valid, o_pc, o_prv_we, o_prv, o_mcause_we, o_scause_we, o_cause,
               o_mepc_we, o_sepc_we, o_epc, o_mbad_we, o_sbad_we, o_badaddr,
               o_mstat_we, o_mpie, o_mpp, o_sstat_we, o_spie, o_spp, o_resv_clr,
               o_dbg_enter, o_dbg_cause, o_dbg_prv, o_dpc_we};
      check(req, act_v, exp_v);
      @(negedge clk);
      check("R1 idle after request", {240'd0, strobes_now()}, 256'd0);
   endtask

   initial begin
      repeat (2000000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] idxs [7];
      logic [31:0] masks [3];
      idxs  = '{32'd0, 32'd1, 32'd3, 32'd5, 32'd9, 32'd31, 32'd40};
      masks = '{32'h0, 32'hFFFF_FFFF, 32'hAAAA_AAAA};
      repeat (3) @(negedge clk);
      check("R1 reset state", {240'd0, strobes_now()}, 256'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 quiet after reset", {240'd0, strobes_now()}, 256'd0);

      // R4 R5 R6 R7 R8 R9 R10: routing sweep
      for (int p = 0; p < 4; p++)
         for (int k = 0; k < 2; k++)
            for (int c = 0; c < 7; c++)
               for (int m = 0; m < 3; m++)
                  for (int v = 0; v < 2; v++) begin
                     i_prv       = 2'(p);
                     i_cause     = {k[0], idxs[c][30:0]};
                     i_epc       = 32'h1000_0000 + 32'(p * 64 + c * 4);
                     i_badaddr   = 32'hBAD0_0000 + 32'(c);
                     i_bad_vld   = (c % 2) == 0;
                     i_mie       = m[0];
                     i_sie       = v[0] ^ k[0];
                     i_mtvec     = 32'h0000_4002 | 32'(v);
                     i_stvec     = 32'h0000_6003;
                     i_medeleg   = masks[m];
                     i_mideleg   = ~masks[m];
                     i_ebreak_en = 4'h0;
                     i_dbg_cause = 3'd0;
                     run_trap("R4 R5 R6 R7 R8 R9 R10 routing");
                  end

      // R2 R3: breakpoint and debug-mode sweep
      for (int p = 0; p < 4; p++)
         for (int e = 0; e < 16; e++)
            for (int d = 0; d < 2; d++)
               for (int b = 0; b < 2; b++) begin
                  i_prv       = 2'(p);
                  i_ebreak_en = 4'(e);
                  i_dbg_cause = d ? 3'd3 : 3'd0;
                  i_cause     = b ? 32'd3 : 32'd2;
                  i_medeleg   = 32'hFFFF_FFFF;
                  i_mideleg   = 32'h0;
                  i_bad_vld   = 1'b1;
                  i_epc       = 32'h2000_0000 + 32'(e);
                  run_trap("R2 R3 debug priority");
               end

      // R3: interrupt while in debug mode
      i_dbg_cause = 3'd1; i_ebreak_en = 4'hF; i_cause = 32'h8000_0003; i_prv = 2'd0;
      run_trap("R3 interrupt in debug mode");
      // R7: vectored machine interrupt at high index
      i_dbg_cause = 3'd0; i_ebreak_en = 4'h0; i_prv = 2'd3; i_mideleg = '1;
      i_mtvec = 32'h0000_8001; i_cause = 32'h8000_000B;
      run_trap("R7 vectored offset");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule